// File: doc/BRIEF.md
# Rate 2/3 Feedback Convolutional Encoder

This block turns a stream of 2-bit data words into 3-bit coded symbols, one symbol per accepted word. The symbol is an index from 0 to 7 that a later stage maps onto one of eight phase points. The upper data bit is copied into the top symbol bit without coding. The lower data bit drives a four-state trellis machine built from two delay flip-flops with feedback. Because only one bit is coded, each trellis branch carries a pair of signal points that differ only in the uncoded bit.

A word is accepted on any clock edge where `in_valid` is high. The coded symbol and `out_valid` appear one register stage later. On cycles without a valid word, the trellis state and the last symbol are held. A synchronous reset puts the trellis back in its zero state. This is the only form of flushing the block provides.

The trellis state is held as an enumerated type with a 2-bit encoding: bit 1 is the second delay (d2) and bit 0 is the first delay (d1). The four states are TS_ZERO (d2=0, d1=0), TS_D1 (d2=0, d1=1), TS_D2 (d2=1, d1=0) and TS_BOTH (d2=1, d1=1). On an accepted word whose lower bit is x0, the next state has d1 = x0 XOR d2 and d2 = the old d1. This gives eight transitions:
- TS_ZERO goes to TS_ZERO or TS_D1.
- TS_D1 goes to TS_D2 or TS_BOTH.
- TS_D2 goes to TS_D1 or TS_ZERO.
- TS_BOTH goes to TS_BOTH or TS_D2.

In each pair, the first target is for x0=0 and the second for x0=1.

Top module: `cc23_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` becomes 0, `out_sym` becomes 0 and the trellis enters TS_ZERO.
- R2: For each accepted word, `out_sym[2]` equals `in_bits[1]` of that word.
- R3: For each accepted word, `out_sym[1]` equals `in_bits[0]` XOR d2, where d2 is the value held when the word is accepted.
- R4: For each accepted word, `out_sym[0]` equals d1 held when the word is accepted.
- R5: On an accepted word, d1 takes the value of the coded bit just produced (symbol bit 1) and d2 takes the old d1.
- R6: Cycles with `in_valid` low have no effect. They change neither the trellis state nor `out_sym`.
- R7: `out_valid` equals the value of `in_valid` one clock earlier, and `out_sym` carries the symbol for the word accepted on that edge.
- R8: A reset in the middle of a stream returns the encoder to TS_ZERO. The first symbol after it has bit 0 equal to 0 and bit 1 equal to `in_bits[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data word strobe |
| in_bits | input | 2 | Data word; bit 1 uncoded, bit 0 coded |
| out_valid | output | 1 | Symbol strobe, one cycle after `in_valid` |
| out_sym | output | 3 | Coded symbol index 0 to 7 |

## Verification
Directed runs of constant words (all zeros, all ones, lower bit held at 1) walk fixed loops of the trellis. These loops reveal a wrong feedback tap or a swapped pair of delays, since the symbol bits 1 and 0 then cycle through the wrong periodic pattern. Long random streams with a random valid strobe separate correct holding on idle cycles from a state that advances on every clock. A reset in the middle of a stream, followed by a word with the lower bit set, shows whether both delays really return to zero.

// File: rtl/cc23_pkg.sv
package cc23_pkg;

    localparam int IN_W  = 2;
    localparam int SYM_W = IN_W + 1;
    localparam int ST_W  = 2;

    // bit 1 = second delay (d2), bit 0 = first delay (d1)
    typedef enum logic [ST_W-1:0] {
        TS_ZERO = 2'b00,
        TS_D1   = 2'b01,
        TS_D2   = 2'b10,
        TS_BOTH = 2'b11
    } trellis_state_t;

    typedef logic [IN_W-1:0]  word_t;
    typedef logic [SYM_W-1:0] sym_t;

endpackage

// File: rtl/cc23_trellis_fsm.sv
module cc23_trellis_fsm
    import cc23_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic           x0,
    output trellis_state_t state_q
);

    trellis_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                TS_ZERO: state_d = x0 ? TS_D1   : TS_ZERO;
                TS_D1:   state_d = x0 ? TS_BOTH : TS_D2;
                TS_D2:   state_d = x0 ? TS_ZERO : TS_D1;
                TS_BOTH: state_d = x0 ? TS_D2   : TS_BOTH;
                default: state_d = TS_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/cc23_branch_map.sv
module cc23_branch_map
    import cc23_pkg::*;
(
    input  trellis_state_t state,
    input  word_t          word,
    output sym_t           sym
);

    logic [1:0] coded;

    always_comb begin
        coded = 2'b00;
        unique case (state)
            TS_ZERO: coded = {word[0],  1'b0};
            TS_D1:   coded = {word[0],  1'b1};
            TS_D2:   coded = {~word[0], 1'b0};
            TS_BOTH: coded = {~word[0], 1'b1};
            default: coded = 2'b00;
        endcase
        sym = {word[IN_W-1], coded};
    end

endmodule

// File: rtl/cc23_out_stage.sv
module cc23_out_stage
    import cc23_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  sym_t sym_in,
    output logic valid_q,
    output sym_t sym_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            sym_q   <= '0;
        end else begin
            valid_q <= load;
            if (load) begin
                sym_q <= sym_in;
            end
        end
    end

endmodule

// File: rtl/cc23_encoder.sv
module cc23_encoder
    import cc23_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_bits,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym
);

    trellis_state_t state_q;
    sym_t           sym_c;

    cc23_trellis_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .x0      (in_bits[0]),
        .state_q (state_q)
    );

    cc23_branch_map u_map (
        .state (state_q),
        .word  (in_bits),
        .sym   (sym_c)
    );

    cc23_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .sym_in  (sym_c),
        .valid_q (out_valid),
        .sym_q   (out_sym)
    );

endmodule

// File: rtl/cc23_encoder_chk.sv
module cc23_encoder_chk
    import cc23_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_bits,
    input logic             out_valid,
    input logic [SYM_W-1:0] out_sym,
    input logic [ST_W-1:0]  st
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sym == '0 && st == '0));

    a_r2_uncoded_copy: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sym[2] == $past(in_bits[1]));

    a_r3_coded_bit: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sym[1] == ($past(in_bits[0]) ^ $past(st[1])));

    a_r4_delay_bit: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sym[0] == $past(st[0]));

    a_r5_state_step: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (st[0] == out_sym[1] && st[1] == $past(st[0])));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sym) && $stable(st)));

    a_r7_valid_high: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

bind cc23_encoder cc23_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bits   (in_bits),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .st        (state_q)
);

// File: tb/cc23_encoder_tb_top.sv
`timescale 1ns/1ps
module cc23_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_bits = 2'b00;
    logic       out_valid;
    logic [2:0] out_sym;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic       m_d1 = 1'b0;
    logic       m_d2 = 1'b0;
    logic [2:0] m_sym = 3'b000;

    always #10 clk = ~clk;

    cc23_encoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_sym   (out_sym)
    );

    function automatic logic [2:0] ref_sym(logic [1:0] w, logic d1, logic d2);
        return {w[1], w[0] ^ d2, d1};
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        m_d1 = 1'b0;
        m_d2 = 1'b0;
        m_sym = 3'b000;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_sym", int'(out_sym), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(logic v, logic [1:0] w);
        logic nd1;
        @(negedge clk);
        in_valid = v;
        in_bits = w;
        if (v) begin
            m_sym = ref_sym(w, m_d1, m_d2);
            nd1 = w[0] ^ m_d2;
            m_d2 = m_d1;
            m_d1 = nd1;
        end
        @(posedge clk);
        #1;
        check("R7 out_valid", int'(out_valid), int'(v));
        if (v) begin
            check("R2 sym bit2", int'(out_sym[2]), int'(m_sym[2]));
            check("R3 sym bit1", int'(out_sym[1]), int'(m_sym[1]));
            check("R4/R5 sym bit0", int'(out_sym[0]), int'(m_sym[0]));
        end else begin
            check("R6 idle hold", int'(out_sym), int'(m_sym));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0203));
        do_reset();
        // constant zeros stay in zero state
        for (int i = 0; i < 4; i++) step(1'b1, 2'b00);
        // lower bit held high walks the trellis loop
        for (int i = 0; i < 8; i++) step(1'b1, 2'b01);
        for (int i = 0; i < 6; i++) step(1'b1, 2'b11);
        // idle cycles between words
        step(1'b0, 2'b11);
        step(1'b0, 2'b01);
        step(1'b1, 2'b10);
        step(1'b0, 2'b00);
        step(1'b1, 2'b01);
        // R8: reset mid-stream
        do_reset();
        step(1'b1, 2'b01);
        check("R8 first sym bit0", int'(out_sym[0]), 0);
        check("R8 first sym bit1", int'(out_sym[1]), 1);
        // random traffic
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4));
            if (i == 200) begin
                do_reset();
                step(1'b1, 2'b11);
                check("R8 after random reset", int'(out_sym), 3'b110);
            end
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule